// File: doc/BRIEF.md
# 1-Wire bus master engine

This block is the timing engine of a 1-Wire master. It drives one open-drain line, which an external resistor pulls high. The line is driven through an output enable: a high enable pulls the wire low. The level of the wire comes back through a synchroniser. A divider turns the system clock into a one-microsecond tick, and every bus timing is counted in those ticks.

The block takes one command at a time. There are two kinds:

- A bus reset, which checks for a presence answer from a device and for a wire held low.
- A single bit slot, which writes one bit and reads one bit back in the same slot.

A bit slot can also ask for the strong pull-up output to turn on once the slot has ended, so that a parasite-powered device can draw current. The strong pull-up stays on until the next command is taken.

Commands enter on a valid/ready pair:

- `cmd_ready` is high only while the engine is idle.
- A command transfers on a clock edge where both `cmd_valid` and `cmd_ready` are high.
- While the engine is busy, `cmd_ready` is low and `cmd_valid` is ignored, so the source simply holds its request.
- Results are not back-pressured. `done` pulses for one clock, and the result flags are valid from that cycle until the next command is taken.
- `cmd_ready` is already high in the cycle of `done`, so commands can run back to back.

Top module: `owm_engine`

## Requirements
- R1: A reset command (`cmd_op`=1) drives `bus_oe` high for exactly T_RST_LOW_US (480) microseconds from acceptance, then releases the line.
- R2: In a reset, the line is sampled T_PRES_US (64) microseconds after release. A high level sets `pres_err`=1 (no device answered); a low level gives `pres_err`=0.
- R3: In a reset, the line is sampled again T_RST_WIN_US (480) microseconds after release. A low level sets `short_err`=1; a high level gives `short_err`=0. For a bit slot, both `pres_err` and `short_err` read 0.
- R4: A bit slot (`cmd_op`=0) always drives the line low for T_INIT_US (2) microseconds. When `cmd_wbit`=1, the line is released at that point.
- R5: When `cmd_wbit`=0, the line stays low for T_SLOT_US (60) microseconds and is then released.
- R6: `rx_bit` equals `cmd_wbit` ANDed with the line level at T_SAMP_US (15) microseconds into the slot.
- R7: `done` is a one-clock pulse. It occurs SYNC_STAGES clocks after the command's end point: 960 µs for a reset, and T_SLOT_US+T_REC_US (70) µs for a slot. `busy` is high from acceptance until that pulse.
- R8: A command is taken only when `cmd_ready` is high. `cmd_valid` asserted while busy has no effect on the running command or its timing.
- R9: For a slot accepted with `cmd_spu`=1, `spu_en` rises on the same clock edge as the 60 µs release and stays high until the next command is accepted. `spu_en` and `bus_oe` are never high together.
- R10: One microsecond is CLK_MHZ clocks. Each sample reflects the line level at its microsecond edge, because the capture is delayed by exactly the synchroniser latency.
- R11: After reset, the engine is idle: `cmd_ready`=1, and `bus_oe`, `spu_en` and `done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle; a command is taken on valid and ready |
| cmd_op | input | 1 | 1 = bus reset, 0 = bit slot |
| cmd_wbit | input | 1 | Bit to write in a slot (1 also reads) |
| cmd_spu | input | 1 | Turn on strong pull-up after the slot |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-clock completion pulse |
| rx_bit | output | 1 | Bit read in the last slot |
| pres_err | output | 1 | Last reset saw no presence answer |
| short_err | output | 1 | Last reset found the line held low |
| bus_oe | output | 1 | Pull the line low when high |
| bus_in | input | 1 | Raw line level from the pad |
| spu_en | output | 1 | Strong pull-up enable |

## Verification
Two pairs of events share a cycle in this block.

The first pair is the 60 µs slot edge. It releases the line and also turns on the strong pull-up. The bench records the exact edge where `spu_en` rises, checks that it is the release edge, and checks on every cycle that `bus_oe` is low whenever `spu_en` is high.

The second pair is the completion pulse and the acceptance of a new command. Every command in the sweep is presented in the `done` cycle of the one before it. The next command's timing is then measured from that accept edge, and `spu_en` must be clear one cycle after it.

// File: rtl/owm_pkg.sv
`timescale 1ns/1ps
package owm_pkg;

  typedef enum logic {
    OP_SLOT  = 1'b0,
    OP_RESET = 1'b1
  } owm_op_e;

  typedef struct packed {
    owm_op_e op;
    logic    wbit;
    logic    spu;
  } owm_cmd_t;

endpackage

// File: rtl/owm_tick.sv
`timescale 1ns/1ps
module owm_tick #(
  parameter int DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic tick_o
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] div_q;

  assign tick_o = (div_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (clr_i)  div_q <= '0;
    else if (tick_o) div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end

  generate
    if (DIV > 1) begin : g_gap
      // R10: ticks are spaced by the divider, never back to back
      a_r10_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && !clr_i) |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/owm_sync.sv
`timescale 1ns/1ps
module owm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '1;
    else        sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/owm_seq.sv
`timescale 1ns/1ps
module owm_seq
  import owm_pkg::*;
#(
  parameter int T_RST_LOW = 480,
  parameter int T_PRES    = 64,
  parameter int T_RST_WIN = 480,
  parameter int T_INIT    = 2,
  parameter int T_SAMP    = 15,
  parameter int T_SLOT    = 60,
  parameter int T_REC     = 10,
  parameter int LAT       = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick_i,
  input  logic     start_i,
  input  owm_cmd_t cmd_i,
  input  logic     line_i,
  output logic     busy_o,
  output logic     done_o,
  output logic     bus_oe_o,
  output logic     spu_en_o,
  output logic     pres_err_o,
  output logic     short_err_o,
  output logic     rx_bit_o
);
  localparam int RST_END  = T_RST_LOW + T_RST_WIN;
  localparam int SLOT_END = T_SLOT + T_REC;
  localparam int MAX_END  = (RST_END > SLOT_END) ? RST_END : SLOT_END;
  localparam int CW       = $clog2(MAX_END + 1);

  localparam logic [CW-1:0] C_RST_LOW  = CW'(T_RST_LOW);
  localparam logic [CW-1:0] C_PRES     = CW'(T_RST_LOW + T_PRES);
  localparam logic [CW-1:0] C_RST_END  = CW'(RST_END);
  localparam logic [CW-1:0] C_INIT     = CW'(T_INIT);
  localparam logic [CW-1:0] C_SAMP     = CW'(T_SAMP);
  localparam logic [CW-1:0] C_SLOT     = CW'(T_SLOT);
  localparam logic [CW-1:0] C_SLOT_END = CW'(SLOT_END);

  owm_cmd_t        cmd_q;
  logic [CW-1:0]   cnt_q, cnt_nx, end_at;
  logic            run_q, busy_q, done_q, oe_q, spu_q, pe_q, se_q, rx_q;
  logic [LAT-1:0]  pres_pipe, samp_pipe, end_pipe;
  logic            step, is_rst, ev_pres, ev_samp, ev_end, oe_nx;

  assign is_rst  = (cmd_q.op == OP_RESET);
  assign step    = run_q & tick_i;
  assign cnt_nx  = cnt_q + 1'b1;
  assign end_at  = is_rst ? C_RST_END : C_SLOT_END;
  assign ev_pres = step &  is_rst & (cnt_nx == C_PRES);
  assign ev_samp = step & !is_rst & (cnt_nx == C_SAMP);
  assign ev_end  = step & (cnt_nx == end_at);

  // Pad enable for the microsecond that starts at this tick
  always_comb begin
    if (is_rst) oe_nx = (cnt_nx < C_RST_LOW);
    else        oe_nx = (cnt_nx < C_INIT) | (!cmd_q.wbit & (cnt_nx < C_SLOT));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= '0;
      cnt_q     <= '0;
      run_q     <= 1'b0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      oe_q      <= 1'b0;
      spu_q     <= 1'b0;
      pe_q      <= 1'b0;
      se_q      <= 1'b0;
      rx_q      <= 1'b0;
      pres_pipe <= '0;
      samp_pipe <= '0;
      end_pipe  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        cmd_q     <= cmd_i;
        cnt_q     <= '0;
        run_q     <= 1'b1;
        busy_q    <= 1'b1;
        oe_q      <= 1'b1;
        spu_q     <= 1'b0;
        pe_q      <= 1'b0;
        se_q      <= 1'b0;
        rx_q      <= 1'b0;
        pres_pipe <= '0;
        samp_pipe <= '0;
        end_pipe  <= '0;
      end else begin
        if (step) begin
          cnt_q <= cnt_nx;
          oe_q  <= oe_nx;
          if (!is_rst && cmd_q.spu && (cnt_nx == C_SLOT)) spu_q <= 1'b1;
          if (ev_end) run_q <= 1'b0;
        end
        // Delay each sample by the synchroniser depth
        pres_pipe <= (pres_pipe << 1) | LAT'(ev_pres);
        samp_pipe <= (samp_pipe << 1) | LAT'(ev_samp);
        end_pipe  <= (end_pipe  << 1) | LAT'(ev_end);
        if (pres_pipe[LAT-1]) pe_q <= line_i;
        if (samp_pipe[LAT-1]) rx_q <= cmd_q.wbit & line_i;
        if (end_pipe[LAT-1]) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          if (is_rst) se_q <= !line_i;
        end
      end
    end
  end

  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign bus_oe_o    = oe_q;
  assign spu_en_o    = spu_q;
  assign pres_err_o  = pe_q;
  assign short_err_o = se_q;
  assign rx_bit_o    = rx_q;

  // R9: strong pull-up only on a released line
  a_r9_spu_released: assert property (@(posedge clk) disable iff (!rst_n)
    spu_q |-> !oe_q);
  // R7: completion is a single-cycle pulse
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R7: busy ends only with a completion pulse
  a_r7_busy_ends_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);
  // R1: the line is pulled only while a command runs
  a_r1_oe_in_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> busy_q);
  // R8: a running command is never replaced
  a_r8_cmd_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(cmd_q));
  // R6: writing zero always reads zero
  a_r6_zero_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !is_rst && !cmd_q.wbit) |-> !rx_q);
endmodule

// File: rtl/owm_engine.sv
`timescale 1ns/1ps
module owm_engine
  import owm_pkg::*;
#(
  parameter int CLK_MHZ      = 50,
  parameter int SYNC_STAGES  = 2,
  parameter int T_RST_LOW_US = 480,
  parameter int T_PRES_US    = 64,
  parameter int T_RST_WIN_US = 480,
  parameter int T_INIT_US    = 2,
  parameter int T_SAMP_US    = 15,
  parameter int T_SLOT_US    = 60,
  parameter int T_REC_US     = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  output logic cmd_ready,
  input  logic cmd_op,
  input  logic cmd_wbit,
  input  logic cmd_spu,
  output logic busy,
  output logic done,
  output logic rx_bit,
  output logic pres_err,
  output logic short_err,
  output logic bus_oe,
  input  logic bus_in,
  output logic spu_en
);
  logic     accept, tick, line_s, busy_w;
  owm_cmd_t cmd_w;

  assign cmd_ready = !busy_w;
  assign busy      = busy_w;
  assign accept    = cmd_valid & cmd_ready;
  assign cmd_w     = '{op: owm_op_e'(cmd_op), wbit: cmd_wbit, spu: cmd_spu};

  owm_tick #(.DIV(CLK_MHZ)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (accept),
    .tick_o (tick)
  );

  owm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (bus_in),
    .q_o   (line_s)
  );

  owm_seq #(
    .T_RST_LOW (T_RST_LOW_US),
    .T_PRES    (T_PRES_US),
    .T_RST_WIN (T_RST_WIN_US),
    .T_INIT    (T_INIT_US),
    .T_SAMP    (T_SAMP_US),
    .T_SLOT    (T_SLOT_US),
    .T_REC     (T_REC_US),
    .LAT       (SYNC_STAGES)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick),
    .start_i     (accept),
    .cmd_i       (cmd_w),
    .line_i      (line_s),
    .busy_o      (busy_w),
    .done_o      (done),
    .bus_oe_o    (bus_oe),
    .spu_en_o    (spu_en),
    .pres_err_o  (pres_err),
    .short_err_o (short_err),
    .rx_bit_o    (rx_bit)
  );

  // R8: nothing is taken while a command runs
  a_r8_ready_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && busy_w) |=> $stable(bus_oe) || busy_w);
endmodule

// File: tb/tb_owm_engine.sv
`timescale 1ns/1ps
module tb_owm_engine;
  localparam int M = 2;   // clocks per microsecond
  localparam int N = 2;   // synchroniser depth

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_op = 1'b0, cmd_wbit = 1'b0, cmd_spu = 1'b0;
  logic cmd_ready, busy, done, rx_bit, pres_err, short_err, bus_oe, spu_en;
  logic dev_low = 1'b0;
  logic bus_in;
  int   n_chk = 0, n_fail = 0, cyc = 0;
  bit   finished = 1'b0;

  assign bus_in = !(bus_oe || dev_low);

  always #2 clk = ~clk;

  owm_engine #(.CLK_MHZ(M), .SYNC_STAGES(N)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_wbit(cmd_wbit), .cmd_spu(cmd_spu), .busy(busy),
    .done(done), .rx_bit(rx_bit), .pres_err(pres_err), .short_err(short_err),
    .bus_oe(bus_oe), .bus_in(bus_in), .spu_en(spu_en)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // Device model: 0 silent, 1 answers/pulls low, 2 line shorted (reset only)
  function automatic logic dev_model(input logic op, input int dev, input int k);
    if (op) begin
      if (dev == 2) return 1'b1;
      if (dev == 1) return (k >= 500*M) && (k < 630*M);
      return 1'b0;
    end
    if (dev == 1) return (k >= M) && (k < 30*M);
    return 1'b0;
  endfunction

  // Called just after a negedge; the previous command's done cycle if any.
  task automatic run_cmd(input logic op, input logic wb, input logic sp, input int dev);
    int k, oe_n, spu_k, done_k, exp_done, exp_oe, exp_spu;
    logic g_rx, g_pe, g_se;
    chk(cmd_ready === 1'b1, "R8 ready in idle/done cycle", cmd_ready, 1);
    cmd_valid = 1'b1; cmd_op = op; cmd_wbit = wb; cmd_spu = sp;
    @(posedge clk);
    k = 0; oe_n = 0; spu_k = -1; done_k = -1;
    g_rx = 1'b0; g_pe = 1'b0; g_se = 1'b0;
    forever begin
      @(negedge clk);
      if (k >= 5 && k < 9) begin
        // R8: conflicting request while busy must be ignored
        cmd_valid = 1'b1; cmd_op = !op; cmd_wbit = !wb; cmd_spu = 1'b0;
        if (k == 5) chk(cmd_ready === 1'b0, "R8 not ready while busy", cmd_ready, 0);
      end else begin
        cmd_valid = 1'b0;
      end
      dev_low = dev_model(op, dev, k);
      if (k == 0) chk(spu_en === 1'b0, "R9 spu cleared on accept", spu_en, 0);
      if (spu_en && bus_oe) chk(1'b0, "R9 spu with line pulled", k, -1);
      if (bus_oe) oe_n++;
      if (spu_en && spu_k < 0) spu_k = k;
      if (done) begin
        done_k = k; g_rx = rx_bit; g_pe = pres_err; g_se = short_err;
        break;
      end
      if (k > 4000) break;
      @(posedge clk);
      k++;
    end
    dev_low = 1'b0;
    exp_done = (op ? 960 : 70) * M + N;
    exp_oe   = op ? 480*M : (wb ? 2*M : 60*M);
    exp_spu  = (!op && sp) ? 60*M : -1;
    chk(done_k == exp_done, "R7 R10 done cycle", done_k, exp_done);
    if (op) begin
      chk(oe_n == exp_oe, "R1 reset low time", oe_n, exp_oe);
      chk(g_pe == (dev == 0), "R2 presence flag", g_pe, int'(dev == 0));
      chk(g_se == (dev == 2), "R3 short flag", g_se, int'(dev == 2));
    end else begin
      if (wb) chk(oe_n == exp_oe, "R4 init low time", oe_n, exp_oe);
      else    chk(oe_n == exp_oe, "R5 zero slot low time", oe_n, exp_oe);
      chk(g_rx == (wb && dev != 1), "R6 read bit", g_rx, int'(wb && dev != 1));
      chk(!g_pe && !g_se, "R3 flags clear in slot", {g_pe, g_se}, 0);
      chk(spu_k == exp_spu, "R9 spu rise edge", spu_k, exp_spu);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: idle after reset
    chk(cmd_ready === 1'b1 && bus_oe === 1'b0 && spu_en === 1'b0 && done === 1'b0,
        "R11 reset state", {cmd_ready, bus_oe, spu_en, done}, 8);
    rst_n = 1'b1;
    @(negedge clk);
    for (int op = 0; op < 2; op++) begin
      if (op == 0) begin
        for (int wb = 0; wb < 2; wb++)
          for (int dv = 0; dv < 2; dv++)
            for (int sp = 0; sp < 2; sp++)
              run_cmd(1'b0, wb[0], sp[0], dv);
      end else begin
        for (int dv = 0; dv < 3; dv++) run_cmd(1'b1, 1'b0, 1'b0, dv);
      end
    end
    run_cmd(1'b0, 1'b1, 1'b1, 0);
    run_cmd(1'b1, 1'b1, 1'b1, 1);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule